// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block is a synthesizable behavioural model of a byte-wide parallel NOR flash. It sits behind a plain bus made of an address, a write byte with a write strobe, and a read strobe with a registered read byte. Inside, a small array is divided into equal sectors. Every bus write passes through a command-cycle state machine. That machine decides whether the byte is a command, an argument, data to store or a confirm code. It also decides whether later reads return array contents, the status register or a fixed identification (query) table.

Supported operations are array read, single-byte program, sector erase with a confirm step, counted buffered write with a trailing confirm, status clear, status read, and lock/unlock. Lock/unlock is accepted but protects nothing. A query mode returns identification bytes. Real program and erase timing is not modelled: each operation completes in the cycle its write arrives. Three debug outputs expose the active command, the command cycle and the status register, so a testbench can follow the sequencer directly.

Top module: `nor_cmd_top`

## Requirements
- R1: After reset the active command is 0x00 (read array), the command cycle is 0, the status register is 0x00, every array byte reads 0xFF and the read output is 0x00.
- R2: The read byte is registered and appears the cycle after the read strobe. With active command 0x00 it comes from the array. With 0x20, 0x60, 0x70 or 0xE8 it is the status register. With 0x98 it comes from the query table.
- R3: In cycle 0, a write of 0x10 or 0x40 moves to cycle 1. The next write stores its byte at its address, sets status bit 7 (ready) and returns to read array in cycle 0.
- R4: In cycle 0, a write of 0x20 fills the whole sector that holds the write address with 0xFF at once, sets ready and moves to cycle 1. A following 0xD0 returns to cycle 0 with the command kept at 0x20. Any other byte returns to read array.
- R5: In cycle 0, a write of 0x50 clears the whole status register and returns to read array.
- R6: In cycle 0, a write of 0x70 makes 0x70 the active command and leaves the cycle at 0, so the next write is decoded as a new command.
- R7: In cycle 0, a write of 0xE8 sets ready and moves to cycle 1. The next write loads a count N and moves to cycle 2. Data writes then store bytes and set ready. The write that finds the count at zero moves to cycle 3, so N+1 bytes are stored. In cycle 3, 0xD0 returns to cycle 0 with command 0xE8 kept. Any other byte returns to read array.
- R8: In cycle 0, a write of 0x60 moves to cycle 1. A following 0xD0 or 0x01 sets ready and returns to cycle 0 with command 0x60 kept. Any other byte returns to read array. Locking never blocks a later program.
- R9: In cycle 0, a write of 0x98 enters query mode in cycle 1. Reads return the table byte at the low 8 address bits: 0x51, 0x52, 0x59 and 0x01 at offsets 0x10 to 0x13, and 0x00 above offset 0x52. A write of 0xFF leaves query mode; any other write keeps it.
- R10: In cycle 0, writes of 0x00, 0xFF or any byte that is not a command return to read array in cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address for reads and writes |
| bus_wdata | input | 8 | Write byte (command, argument or data) |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read byte, valid the cycle after the read strobe |
| dbg_cmd | output | 8 | Active command byte (0x00 in read array) |
| dbg_cycle | output | 2 | Command cycle 0 to 3 |
| dbg_status | output | 8 | Status register (bit 7 = ready) |

## Verification
The sequencer is driven with complete, well-formed sequences for each command. It is also driven with truncated or corrupted ones: a bad erase confirm, an unknown lock argument, a non-0xD0 byte in the buffered-write confirm, and unknown opcodes. The good and broken sequences are separated by the command and cycle they leave behind. Reads after each sequence use both sides of a sector boundary, which shows that erase reaches exactly one sector. A buffered write with a count of 2 and one with a count of 0 show that one more byte is stored than the count says. Query reads below and above the table end, and a status read just after 0x70, separate the three read sources.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE    = 2'd0,
    CYC_ARG     = 2'd1,
    CYC_DATA    = 2'd2,
    CYC_CONFIRM = 2'd3
  } cyc_e;

  localparam logic [7:0] OP_NONE     = 8'h00;
  localparam logic [7:0] OP_PROG_A   = 8'h10;
  localparam logic [7:0] OP_PROG_B   = 8'h40;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_CLRST    = 8'h50;
  localparam logic [7:0] OP_LOCK     = 8'h60;
  localparam logic [7:0] OP_RDST     = 8'h70;
  localparam logic [7:0] OP_QUERY    = 8'h98;
  localparam logic [7:0] OP_BUFWR    = 8'hE8;
  localparam logic [7:0] OP_ARRAY    = 8'hFF;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_LOCK_ALT = 8'h01;

  localparam logic [7:0] READY_MASK  = 8'h80;
  localparam logic [7:0] QUERY_LAST  = 8'h52;

endpackage

// File: rtl/nor_query_rom.sv
module nor_query_rom #(
  parameter int SECT_BYTES = 64,
  parameter int NUM_SECT   = 4
) (
  input  logic [7:0] off_i,
  output logic [7:0] byte_o
);
  import nor_cmd_pkg::*;

  localparam int TOTAL_BYTES = SECT_BYTES * NUM_SECT;
  localparam int TOTAL_LOG2  = $clog2(TOTAL_BYTES);
  localparam logic [15:0] SECT_M1 = 16'(NUM_SECT - 1);
  localparam logic [23:0] SECT_SZ = 24'(SECT_BYTES);

  always_comb begin
    byte_o = 8'h00;
    if (off_i <= QUERY_LAST) begin
      case (off_i)
        8'h10: byte_o = 8'h51;
        8'h11: byte_o = 8'h52;
        8'h12: byte_o = 8'h59;
        8'h13: byte_o = 8'h01;
        8'h15: byte_o = 8'h31;
        8'h1B: byte_o = 8'h45;
        8'h1C: byte_o = 8'h55;
        8'h1F: byte_o = 8'h07;
        8'h20: byte_o = 8'h07;
        8'h21: byte_o = 8'h0A;
        8'h23: byte_o = 8'h04;
        8'h24: byte_o = 8'h04;
        8'h25: byte_o = 8'h04;
        8'h27: byte_o = 8'(TOTAL_LOG2);
        8'h28: byte_o = 8'h02;
        8'h2A: byte_o = 8'h0B;
        8'h2C: byte_o = 8'h01;
        8'h2D: byte_o = SECT_M1[7:0];
        8'h2E: byte_o = SECT_M1[15:8];
        8'h2F: byte_o = SECT_SZ[15:8];
        8'h30: byte_o = SECT_SZ[23:16];
        8'h31: byte_o = 8'h50;
        8'h32: byte_o = 8'h52;
        8'h33: byte_o = 8'h49;
        8'h34: byte_o = 8'h31;
        8'h35: byte_o = 8'h31;
        default: byte_o = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/nor_array.sv
module nor_array #(
  parameter int SECT_BYTES = 64,
  parameter int NUM_SECT   = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  prog_en,
  input  logic [$clog2(SECT_BYTES*NUM_SECT)-1:0] prog_addr,
  input  logic [7:0]                            prog_data,
  input  logic                                  erase_en,
  input  logic [$clog2(SECT_BYTES*NUM_SECT)-1:0] erase_addr,
  input  logic [$clog2(SECT_BYTES*NUM_SECT)-1:0] rd_addr,
  output logic [7:0]                            rd_byte
);
  localparam int SECT_AW = $clog2(SECT_BYTES);
  localparam int ADDR_W  = $clog2(SECT_BYTES * NUM_SECT);

  logic [NUM_SECT-1:0][7:0] sect_rd;

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    logic [7:0] cells [SECT_BYTES];
    logic       hit_erase;
    logic       hit_prog;

    assign hit_erase = erase_en && (erase_addr[ADDR_W-1:SECT_AW] == s);
    assign hit_prog  = prog_en  && (prog_addr[ADDR_W-1:SECT_AW] == s);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int b = 0; b < SECT_BYTES; b++) cells[b] <= 8'hFF;
      end else if (hit_erase) begin
        for (int b = 0; b < SECT_BYTES; b++) cells[b] <= 8'hFF;
      end else if (hit_prog) begin
        cells[prog_addr[SECT_AW-1:0]] <= prog_data;
      end
    end

    assign sect_rd[s] = cells[rd_addr[SECT_AW-1:0]];
  end

  assign rd_byte = sect_rd[rd_addr[ADDR_W-1:SECT_AW]];

  p_no_prog_during_erase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_en && erase_en));

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        cmd_o,
  output logic [1:0]        cyc_o,
  output logic [7:0]        status_o,
  output logic              prog_en_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [7:0]        prog_data_o,
  output logic              erase_en_o,
  output logic [ADDR_W-1:0] erase_addr_o
);
  import nor_cmd_pkg::*;

  cyc_e       cyc_q, cyc_d;
  logic [7:0] cmd_q, cmd_d;
  logic [7:0] st_q, st_d;
  logic [7:0] cnt_q, cnt_d;
  logic       go_array;

  always_comb begin
    cyc_d      = cyc_q;
    cmd_d      = cmd_q;
    st_d       = st_q;
    cnt_d      = cnt_q;
    prog_en_o  = 1'b0;
    erase_en_o = 1'b0;
    go_array   = 1'b0;
    if (we_i) begin
      case (cyc_q)
        CYC_IDLE: begin
          case (wdata_i)
            OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
              cmd_d = wdata_i;
              cyc_d = CYC_ARG;
            end
            OP_ERASE: begin
              erase_en_o = 1'b1;
              st_d       = st_q | READY_MASK;
              cmd_d      = wdata_i;
              cyc_d      = CYC_ARG;
            end
            OP_BUFWR: begin
              st_d  = st_q | READY_MASK;
              cmd_d = wdata_i;
              cyc_d = CYC_ARG;
            end
            OP_CLRST: begin
              st_d     = 8'h00;
              go_array = 1'b1;
            end
            OP_RDST: begin
              cmd_d = wdata_i;
              cyc_d = CYC_IDLE;
            end
            default: go_array = 1'b1;
          endcase
        end
        CYC_ARG: begin
          case (cmd_q)
            OP_PROG_A, OP_PROG_B: begin
              prog_en_o = 1'b1;
              st_d      = st_q | READY_MASK;
              go_array  = 1'b1;
            end
            OP_ERASE: begin
              if (wdata_i == OP_CONFIRM) begin
                st_d  = st_q | READY_MASK;
                cyc_d = CYC_IDLE;
              end else begin
                go_array = 1'b1;
              end
            end
            OP_BUFWR: begin
              cnt_d = wdata_i;
              cyc_d = CYC_DATA;
            end
            OP_LOCK: begin
              if (wdata_i == OP_CONFIRM || wdata_i == OP_LOCK_ALT) begin
                st_d  = st_q | READY_MASK;
                cyc_d = CYC_IDLE;
              end else begin
                go_array = 1'b1;
              end
            end
            OP_QUERY: begin
              if (wdata_i == OP_ARRAY) go_array = 1'b1;
            end
            default: go_array = 1'b1;
          endcase
        end
        CYC_DATA: begin
          if (cmd_q == OP_BUFWR) begin
            prog_en_o = 1'b1;
            st_d      = st_q | READY_MASK;
            if (cnt_q == 8'h00) cyc_d = CYC_CONFIRM;
            cnt_d = cnt_q - 8'h01;
          end else begin
            go_array = 1'b1;
          end
        end
        CYC_CONFIRM: begin
          if (cmd_q == OP_BUFWR && wdata_i == OP_CONFIRM) begin
            st_d  = st_q | READY_MASK;
            cyc_d = CYC_IDLE;
          end else begin
            go_array = 1'b1;
          end
        end
        default: go_array = 1'b1;
      endcase
      if (go_array) begin
        cmd_d = OP_NONE;
        cyc_d = CYC_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= CYC_IDLE;
      cmd_q <= OP_NONE;
      st_q  <= 8'h00;
      cnt_q <= 8'h00;
    end else if (we_i) begin
      cyc_q <= cyc_d;
      cmd_q <= cmd_d;
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign cmd_o        = cmd_q;
  assign cyc_o        = cyc_q;
  assign status_o     = st_q;
  assign prog_addr_o  = addr_i;
  assign prog_data_o  = wdata_i;
  assign erase_addr_o = addr_i;

  p_data_cycles_bufwr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == CYC_DATA || cyc_q == CYC_CONFIRM) |-> (cmd_q == OP_BUFWR));

  p_clear_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && cyc_q == CYC_IDLE && wdata_i == OP_CLRST)
      |=> (st_q == 8'h00 && cmd_q == OP_NONE));

  p_status_mode_cycle0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && cyc_q == CYC_IDLE && wdata_i == OP_RDST)
      |=> (cyc_q == CYC_IDLE && cmd_q == OP_RDST));

  p_program_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && cyc_q == CYC_ARG && (cmd_q == OP_PROG_A || cmd_q == OP_PROG_B))
      |=> (st_q[7] && cyc_q == CYC_IDLE && cmd_q == OP_NONE));

endmodule

// File: rtl/nor_cmd_top.sv
module nor_cmd_top #(
  parameter int SECT_BYTES = 64,
  parameter int NUM_SECT   = 4,
  parameter int ADDR_W     = $clog2(SECT_BYTES * NUM_SECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata,
  output logic [7:0]        dbg_cmd,
  output logic [1:0]        dbg_cycle,
  output logic [7:0]        dbg_status
);
  import nor_cmd_pkg::*;

  logic              prog_en, erase_en;
  logic [ADDR_W-1:0] prog_addr, erase_addr;
  logic [7:0]        prog_data;
  logic [7:0]        cmd, status;
  logic [1:0]        cyc;
  logic [7:0]        arr_byte, qry_byte, rd_sel;
  logic [7:0]        rdata_q;
  logic [7:0]        qoff;

  if (ADDR_W >= 8) begin : g_qoff_wide
    assign qoff = bus_addr[7:0];
  end else begin : g_qoff_narrow
    assign qoff = {{(8 - ADDR_W){1'b0}}, bus_addr};
  end

  nor_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .we_i         (bus_we),
    .addr_i       (bus_addr),
    .wdata_i      (bus_wdata),
    .cmd_o        (cmd),
    .cyc_o        (cyc),
    .status_o     (status),
    .prog_en_o    (prog_en),
    .prog_addr_o  (prog_addr),
    .prog_data_o  (prog_data),
    .erase_en_o   (erase_en),
    .erase_addr_o (erase_addr)
  );

  nor_array #(.SECT_BYTES(SECT_BYTES), .NUM_SECT(NUM_SECT)) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_en    (prog_en),
    .prog_addr  (prog_addr),
    .prog_data  (prog_data),
    .erase_en   (erase_en),
    .erase_addr (erase_addr),
    .rd_addr    (bus_addr),
    .rd_byte    (arr_byte)
  );

  nor_query_rom #(.SECT_BYTES(SECT_BYTES), .NUM_SECT(NUM_SECT)) u_rom (
    .off_i  (qoff),
    .byte_o (qry_byte)
  );

  always_comb begin
    case (cmd)
      OP_ERASE, OP_CLRST, OP_LOCK, OP_RDST, OP_BUFWR: rd_sel = status;
      OP_QUERY:                                        rd_sel = qry_byte;
      default:                                         rd_sel = arr_byte;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= 8'h00;
    end else if (bus_re) begin
      rdata_q <= rd_sel;
    end
  end

  assign bus_rdata  = rdata_q;
  assign dbg_cmd    = cmd;
  assign dbg_cycle  = cyc;
  assign dbg_status = status;

  p_query_high_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && cmd == OP_QUERY && qoff > QUERY_LAST) |=> (bus_rdata == 8'h00));

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));

endmodule

// File: tb/nor_cmd_top_test.sv
module nor_cmd_top_test;

  logic       clk;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_we;
  logic       bus_re;
  logic [7:0] bus_rdata;
  logic [7:0] dbg_cmd;
  logic [1:0] dbg_cycle;
  logic [7:0] dbg_status;

  int n_chk;
  int n_fail;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  nor_cmd_top uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .bus_rdata  (bus_rdata),
    .dbg_cmd    (dbg_cmd),
    .dbg_cycle  (dbg_cycle),
    .dbg_status (dbg_status)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_addr = a;
    bus_re   = 1'b1;
    @(negedge clk);
    bus_re   = 1'b0;
  endtask

  task automatic st(input logic [7:0] c, input logic [1:0] y, input string tag);
    chk(dbg_cmd, c, {tag, " cmd"});
    chk({6'd0, dbg_cycle}, {6'd0, y}, {tag, " cycle"});
  endtask

  // Monitor: pops the expected byte for every read strobe seen
  initial begin
    forever begin
      @(posedge clk);
      if (bus_re) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          n_chk++;
          n_fail++;
          $display("FAIL R2: read with no expected item, actual 0x%02h expected none", bus_rdata);
        end else begin
          chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00; bus_we = 1'b0; bus_re = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    st(8'h00, 2'd0, "R1");
    chk(dbg_status, 8'h00, "R1 status");
    chk(bus_rdata, 8'h00, "R1 rdata");
    rd(8'h05, 8'hFF, "R1 erased array");
    rd(8'hC7, 8'hFF, "R1 erased array high");

    // R3 single program with 0x40 and 0x10
    wr(8'h05, 8'h40);
    st(8'h40, 2'd1, "R3 armed");
    wr(8'h05, 8'hA5);
    st(8'h00, 2'd0, "R3 done");
    chk(dbg_status, 8'h80, "R3 ready");
    rd(8'h05, 8'hA5, "R3 R2 array byte");
    wr(8'h7F, 8'h10); wr(8'h7F, 8'h3C);
    rd(8'h7F, 8'h3C, "R3 alt opcode");
    wr(8'h45, 8'h40); wr(8'h45, 8'h12);
    wr(8'h80, 8'h40); wr(8'h80, 8'h77);
    wr(8'hC1, 8'h40); wr(8'hC1, 8'h55);

    // R5 clear status
    wr(8'h00, 8'h50);
    st(8'h00, 2'd0, "R5");
    chk(dbg_status, 8'h00, "R5 status");

    // R6 status read then fresh decode
    wr(8'h00, 8'h70);
    st(8'h70, 2'd0, "R6");
    rd(8'h05, 8'h00, "R6 R2 status source");
    wr(8'h06, 8'h40);
    st(8'h40, 2'd1, "R6 fresh decode");
    wr(8'h06, 8'h11);
    rd(8'h06, 8'h11, "R6 program after status");

    // R4 erase sector 1 with confirm
    wr(8'h00, 8'h50);
    wr(8'h4A, 8'h20);
    chk(dbg_status, 8'h80, "R4 ready");
    st(8'h20, 2'd1, "R4 armed");
    rd(8'h45, 8'h80, "R4 R2 status during erase");
    wr(8'h4A, 8'hD0);
    st(8'h20, 2'd0, "R4 confirmed");
    wr(8'h00, 8'hFF);
    st(8'h00, 2'd0, "R10 ff");
    rd(8'h45, 8'hFF, "R4 erased byte");
    rd(8'h40, 8'hFF, "R4 sector start");
    rd(8'h7F, 8'hFF, "R4 sector end");
    rd(8'h3F, 8'hFF, "R4 below sector");
    rd(8'h05, 8'hA5, "R4 sector 0 intact");
    rd(8'h80, 8'h77, "R4 sector 2 intact");

    // R4 bad confirm aborts, erase already done
    wr(8'hC0, 8'h20);
    wr(8'hC0, 8'h33);
    st(8'h00, 2'd0, "R4 bad confirm");
    rd(8'hC1, 8'hFF, "R4 erase at command");

    // R7 buffered write, count 2
    wr(8'h00, 8'h50);
    wr(8'h10, 8'hE8);
    chk(dbg_status, 8'h80, "R7 entry ready");
    st(8'hE8, 2'd1, "R7 entry");
    wr(8'h10, 8'h02);
    st(8'hE8, 2'd2, "R7 count");
    wr(8'h10, 8'hB0);
    wr(8'h11, 8'hB1);
    st(8'hE8, 2'd2, "R7 still data");
    wr(8'h12, 8'hB2);
    st(8'hE8, 2'd3, "R7 confirm cycle");
    wr(8'h00, 8'hD0);
    st(8'hE8, 2'd0, "R7 complete");
    rd(8'h10, 8'h80, "R7 R2 status after");
    wr(8'h00, 8'hFF);
    rd(8'h10, 8'hB0, "R7 word 0");
    rd(8'h11, 8'hB1, "R7 word 1");
    rd(8'h12, 8'hB2, "R7 word 2");
    rd(8'h13, 8'hFF, "R7 no extra word");

    // R7 count 0 and aborted confirm
    wr(8'h20, 8'hE8); wr(8'h20, 8'h00); wr(8'h20, 8'hC3);
    st(8'hE8, 2'd3, "R7 count zero");
    wr(8'h00, 8'h77);
    st(8'h00, 2'd0, "R7 abort");
    rd(8'h20, 8'hC3, "R7 single word");
    rd(8'h21, 8'hFF, "R7 single word only");

    // R8 lock / unlock
    wr(8'h00, 8'h50);
    wr(8'h30, 8'h60); wr(8'h30, 8'h01);
    st(8'h60, 2'd0, "R8 alt code");
    chk(dbg_status, 8'h80, "R8 ready");
    wr(8'h00, 8'h50);
    wr(8'h30, 8'h60); wr(8'h30, 8'hD0);
    st(8'h60, 2'd0, "R8 d0");
    wr(8'h30, 8'h60); wr(8'h30, 8'h99);
    st(8'h00, 2'd0, "R8 unknown arg");
    wr(8'h30, 8'h40); wr(8'h30, 8'h5A);
    rd(8'h30, 8'h5A, "R8 no protection");

    // R9 query
    wr(8'h00, 8'h98);
    st(8'h98, 2'd1, "R9 entry");
    rd(8'h10, 8'h51, "R9 Q");
    rd(8'h11, 8'h52, "R9 R");
    rd(8'h12, 8'h59, "R9 Y");
    rd(8'h13, 8'h01, "R9 cmd set");
    rd(8'h60, 8'h00, "R9 above table");
    rd(8'hFF, 8'h00, "R9 top offset");
    wr(8'h00, 8'h42);
    st(8'h98, 2'd1, "R9 stays");
    rd(8'h10, 8'h51, "R9 still query");
    wr(8'h00, 8'hFF);
    st(8'h00, 2'd0, "R9 leave");
    rd(8'h05, 8'hA5, "R9 R2 array again");

    // R10 unknown and null commands
    wr(8'h00, 8'h33);
    st(8'h00, 2'd0, "R10 unknown");
    rd(8'h05, 8'hA5, "R10 array read");
    wr(8'h00, 8'h70);
    wr(8'h00, 8'h00);
    st(8'h00, 2'd0, "R10 null");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2: actual %0d pending reads expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule